// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address of every beat of a synchronous DRAM burst. A controller presents a starting column, a burst length code and an ordering type, and pulses a start request. From the next clock on, the sequencer presents one column address per clock with a valid flag. It raises a last-beat flag on the final beat of a fixed-length burst. Fixed bursts of 2, 4 or 8 beats stay inside the aligned block that their length defines. A full-row burst walks the whole row until the controller terminates it.

The control is a three-state machine. `ST_IDLE` means no burst is running. `ST_FIXED` runs a burst of 1, 2, 4 or 8 beats. `ST_ROW` runs an open-ended full-row burst. The transitions are:
- idle→fixed or idle→row on a start request, chosen by the length code.
- fixed→idle on the final beat or on a stop request.
- row→idle on a stop request.
- any state→fixed or any state→row on a start request. This restart overrides every other transition.

A separate address unit holds the starting column and forms each beat's column from that column and the beat count. The column width `COL_W` is a parameter: 9 suits a 512-column row, 8 suits a 256-column row.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `beat_valid_o`, `beat_last_o` and `type_err_o` are all low, and they stay low until a start request is seen.
- R2: A start request sampled at a clock edge makes the next cycle beat 0, with `beat_col_o` equal to the starting column. Each further clock advances the burst by one beat.
- R3: For lengths 2, 4 and 8, the column bits above the low log2(N) bits equal those of the starting column on every beat. Passing the block end wraps to the block start.
- R4: With `order_i` = 0 (sequential), beat k has low-bit offset (s + k) mod N, where s is the starting offset. A length-4 burst from column 2 gives 2,3,0,1.
- R5: With `order_i` = 1 (interleaved), beat k has offset s XOR k. A length-8 burst from column 5 gives 5,4,7,6,1,0,3,2.
- R6: Length code 0 gives one beat at the full starting column, with the last-beat flag set, whatever the value of `order_i`.
- R7: The length code `len_code_i` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and any value from 4 to 7 gives a full-row burst.
- R8: A burst of length N raises `beat_last_o` on beat N-1 only. Valid is low in the following cycle unless a new start request was sampled.
- R9: A full-row burst adds one to the column each beat. It wraps from 2^COL_W-1 to 0, never raises `beat_last_o`, and keeps running until it is stopped.
- R10: `stop_i` sampled high at an edge, with no start request, ends any running burst. Valid is low in the next cycle.
- R11: A full-row request with `order_i` = 1 runs in sequential order. `type_err_o` is high during beat 0 only.
- R12: A start request during a burst aborts that burst, and the next cycle is beat 0 of the new burst. A start request takes priority over `stop_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request for a new burst |
| start_col_i | input | COL_W | Starting column, sampled with the start request |
| len_code_i | input | 3 | Burst length code (R7) |
| order_i | input | 1 | 0 = sequential, 1 = interleaved |
| stop_i | input | 1 | Terminate the running burst |
| beat_col_o | output | COL_W | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| beat_last_o | output | 1 | Final beat of a fixed-length burst |
| type_err_o | output | 1 | Interleaved full-row request was downgraded |

## Verification
The bench targets several specific failure modes:
- Start offsets near the block end, where a design that carries out of the low bits would leak into the neighbouring block.
- Interleaved bursts from odd offsets, where an adder used in place of XOR produces a visibly wrong order.
- A full-row burst that starts two columns before the row end, which exposes a counter that saturates or stops instead of wrapping to column 0.
- A restart issued mid-burst together with a stop, which catches a design that lets the stop win or that resumes the old beat count.
- A stop issued during a fixed burst, which catches a design that ignores the stop.
- Interleaved full-row requests, which must run in sequential order and hold the error flag for exactly one cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_ROW   = 2'd2
    } seq_state_e;

    localparam logic [2:0] LEN_ROW_MIN = 3'd4;
endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
    import bcs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       len_code_i,
    input  logic             order_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] mask_o,
    output logic             inter_o,
    output logic             row_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);
    seq_state_e       state_q, state_d;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] mask_q;
    logic [COL_W-1:0] mask_new;
    logic             inter_q;
    logic             err_q;
    logic             is_row;

    assign is_row   = (len_code_i >= LEN_ROW_MIN);
    assign mask_new = is_row ? {COL_W{1'b1}}
                             : (({{(COL_W-1){1'b0}}, 1'b1} << len_code_i[1:0]) - 1'b1);

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = is_row ? ST_ROW : ST_FIXED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_FIXED: state_d = (stop_i || beat_q == mask_q) ? ST_IDLE : ST_FIXED;
                ST_ROW:   state_d = stop_i ? ST_IDLE : ST_ROW;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q  <= '0;
            mask_q  <= '0;
            inter_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (start_i) begin
            beat_q  <= '0;
            mask_q  <= mask_new;
            inter_q <= order_i && !is_row;
            err_q   <= order_i && is_row;
        end else begin
            beat_q  <= beat_q + 1'b1;
            err_q   <= 1'b0;
        end
    end

    assign beat_o  = beat_q;
    assign mask_o  = mask_q;
    assign inter_o = inter_q;
    assign row_o   = (state_q == ST_ROW);
    assign valid_o = (state_q != ST_IDLE);
    assign last_o  = (state_q == ST_FIXED) && (beat_q == mask_q);
    assign err_o   = err_q;

    AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R8
    AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o); // R8
    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !valid_o); // R10
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !start_i) |=> !err_o); // R11
    AST_ROW_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        row_o |-> !last_o); // R9
endmodule

// File: rtl/bcs_addr.sv
module bcs_addr #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             inter_i,
    input  logic             row_i,
    input  logic             valid_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] offset;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      base_q <= '0;
        else if (load_i) base_q <= col_i;
    end

    assign offset = inter_i ? (base_q ^ beat_i) : (base_q + beat_i);
    assign col_o  = (base_q & ~mask_i) | (offset & mask_i);

    AST_BLOCK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !load_i) |=> ((col_o & ~mask_i) == $past(col_o & ~mask_i))); // R3
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (row_i && valid_i && !load_i) |=> (!valid_i || (col_o - $past(col_o)) == COL_W'(1))); // R9
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             order_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] beat_col_o,
    output logic             beat_valid_o,
    output logic             beat_last_o,
    output logic             type_err_o
);
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] mask;
    logic             inter;
    logic             row;

    bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_code_i(len_code_i),
        .order_i(order_i), .stop_i(stop_i), .beat_o(beat), .mask_o(mask),
        .inter_o(inter), .row_o(row), .valid_o(beat_valid_o),
        .last_o(beat_last_o), .err_o(type_err_o)
    );

    bcs_addr #(.COL_W(COL_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load_i(start_i), .col_i(start_col_i),
        .beat_i(beat), .mask_i(mask), .inter_i(inter), .row_i(row),
        .valid_i(beat_valid_o), .col_o(beat_col_o)
    );
endmodule

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;
    localparam int COL_W = 9;
    localparam int ROWN  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             order_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] beat_col_o;
    logic             beat_valid_o, beat_last_o, type_err_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .order_i(order_i), .stop_i(stop_i),
        .beat_col_o(beat_col_o), .beat_valid_o(beat_valid_o),
        .beat_last_o(beat_last_o), .type_err_o(type_err_o)
    );

    function automatic int exp_col(input int s, input int code, input bit il, input int k);
        int n, off, up;
        if (code >= 4) return (s + k) % ROWN;
        n   = 1 << code;
        off = s % n;
        up  = s - off;
        return up + (il ? (off ^ k) : ((off + k) % n));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic beat_check(input int col, input int code, input bit il, input int k,
                              input bit is_last, input string req);
        int e;
        e = exp_col(col, code, il, k);
        chk(beat_valid_o == 1'b1, req, int'(beat_valid_o), 1);
        chk(int'(beat_col_o) == e, req, int'(beat_col_o), e);
        chk(beat_last_o == is_last, {req, " R8"}, int'(beat_last_o), int'(is_last));
        chk(type_err_o == ((k == 0) && code >= 4 && il), "R11", int'(type_err_o),
            int'((k == 0) && code >= 4 && il));
    endtask

    // R2: start sampled at an edge, beat 0 visible at the following negedge
    task automatic burst(input int col, input int code, input bit il, input int row_beats);
        int beats;
        string req;
        @(negedge clk);
        start_i = 1'b1; start_col_i = COL_W'(col); len_code_i = 3'(code); order_i = il;
        @(negedge clk);
        start_i = 1'b0;
        beats = (code >= 4) ? row_beats : (1 << code);
        if (code >= 4)      req = "R9";
        else if (code == 0) req = "R6";
        else if (il)        req = "R5 R3";
        else                req = "R4 R3";
        for (int k = 0; k < beats; k++) begin
            beat_check(col, code, il, k, (code < 4) && (k == beats - 1), {req, " R2 R7"});
            if (k < beats - 1) @(negedge clk);
        end
        if (code >= 4) begin
            stop_i = 1'b1;
            @(negedge clk);
            stop_i = 1'b0;
            chk(!beat_valid_o, "R10", int'(beat_valid_o), 0);
        end else begin
            @(negedge clk);
            chk(!beat_valid_o, "R8", int'(beat_valid_o), 0);
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!beat_valid_o && !beat_last_o && !type_err_o, "R1",
            int'({beat_valid_o, beat_last_o, type_err_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!beat_valid_o, "R1", int'(beat_valid_o), 0);

        burst(2, 2, 1'b0, 0);        // R4: 2,3,0,1
        burst(5, 3, 1'b1, 0);        // R5: 5,4,7,6,1,0,3,2
        burst(13, 3, 1'b0, 0);       // R3: wrap within block 8..15
        burst(301, 0, 1'b1, 0);      // R6: type ignored
        burst(7, 1, 1'b1, 0);        // R7: length 2
        burst(ROWN - 2, 4, 1'b0, 5); // R9: wrap to column 0
        burst(100, 7, 1'b1, 4);      // R11: downgrade to sequential

        // R10: stop a fixed burst after two beats
        @(negedge clk);
        start_i = 1'b1; start_col_i = 9'd3; len_code_i = 3'd3; order_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        beat_check(3, 3, 1'b0, 0, 1'b0, "R10");
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk(!beat_valid_o, "R10", int'(beat_valid_o), 0);

        // R12: restart mid-burst, together with stop
        @(negedge clk);
        start_i = 1'b1; start_col_i = 9'd8; len_code_i = 3'd3; order_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            beat_check(8, 3, 1'b0, k, 1'b0, "R12");
            if (k < 2) @(negedge clk);
        end
        start_i = 1'b1; stop_i = 1'b1; start_col_i = 9'd21; len_code_i = 3'd2; order_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            beat_check(21, 2, 1'b1, k, k == 3, "R12");
            @(negedge clk);
        end
        chk(!beat_valid_o, "R12", int'(beat_valid_o), 0);

        // random bursts
        for (int i = 0; i < 60; i++) begin
            burst(int'($urandom % ROWN), int'($urandom % 8), 1'($urandom), 1 + int'($urandom % 20));
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule